// File: doc/BRIEF.md
# SPI Master Character Shifter

This block is the serial engine of an SPI master. On a start request it takes one parallel transmit character and a 32-bit per-target configuration word. It generates the serial clock at the programmed rate and drives the outgoing data line. It also collects the incoming bits into a parallel receive character. When the character is complete it raises a one-cycle done strobe.

The configuration word sets the following: the clock prescaler, an extra divide-by-16 stage, the character length from 4 to 16 bits, the bit order, and the clock polarity and phase. A loopback input makes the shifter receive its own outgoing bit instead of the external input. Everything that selects how a character is shifted is captured when the character starts, so the surrounding logic may prepare the next configuration while the current one runs.

Top module: `spi_char_shifter`

## Requirements
- R1: While a character runs, every serial clock edge is exactly 2·(P+1) system clock cycles after the previous edge, or after the accepted start for the first edge. P is `cfg_word[27:24]`.
- R2: When `cfg_word[28]` is 1, the spacing between edges is multiplied by 16, giving 32·(P+1) cycles.
- R3: `cfg_word[19:16]` holds the character length N minus one, and values below 3 are treated as 3 (N=4). A character produces 2·N serial clock edges. `busy` stays high for exactly 2·N times the edge spacing, counted in cycles from the accepted start.
- R4: `cfg_word[31]` sets the serial clock idle level. While idle, `sck` follows the bit with one cycle of delay, and it starts and ends each character at that level.
- R5: When `cfg_word[30]` is 0, bit i is on `mosi` from the start (i=0) or from trailing edge i onward, and it is sampled on leading edge i+1. When it is 1, bit i appears on leading edge i+1 and is sampled on the following trailing edge. The first bit is also presented from the start. `mosi` is 0 while idle.
- R6: When `cfg_word[29]` is 1, the character is sent from bit N-1 down to bit 0. When it is 0, it is sent from bit 0 up to bit N-1. Received bits go to the same positions, so `rx_char` is right-aligned, and its bits at N and above are 0.
- R7: When `loop_en` is 1 at the start, the received bits are the bits driven on `mosi`, and `miso` has no effect on `rx_char`.
- R8: `done` is high for exactly one cycle: the cycle in which `busy` has just fallen. `rx_char` takes the new character in that same cycle and holds it until the next done.
- R9: The configuration word and `loop_en` are captured when `start` is accepted. Changes to them during a character do not change that character.
- R10: `start` is accepted only while `busy` is 0, which includes the done cycle. While busy, `start` and `tx_char` are ignored.
- R11: After reset, `busy`, `done`, `sck`, `mosi` and `rx_char` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Per-target configuration word |
| loop_en | input | 1 | Receive from own outgoing data instead of `miso` |
| start | input | 1 | Request to shift one character |
| tx_char | input | 16 | Character to send, right-aligned |
| miso | input | 1 | Serial data from the target |
| busy | output | 1 | Character in progress |
| done | output | 1 | One-cycle strobe at character completion |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the target |
| rx_char | output | 16 | Last received character, right-aligned |

## Verification
Two things can fall in the same clock: the final serial clock edge of one character, which ends `busy`, pulses `done` and loads `rx_char`, and the acceptance of a new `start`. The bench holds `start` high in the done cycle of one character, so that the next character begins on the very next edge. It then checks that the done strobe and the received word of the first character are intact. It also checks that the second character runs with its own configuration and timing. A behavioural reference model, which counts cycles since each accepted start, is compared with `sck`, `mosi`, `busy` and `done` on every clock. A target model driven by the serial clock supplies `miso`.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

    localparam int CFG_W      = 32;
    localparam int CHAR_W     = 16;
    localparam int IDX_W      = $clog2(CHAR_W);
    localparam int PM_W       = 4;
    localparam int SLOW_SHIFT = 5;   // 2 * 16 as a shift
    localparam int FAST_SHIFT = 1;   // 2 as a shift
    localparam int HALF_W     = PM_W + SLOW_SHIFT + 1;
    localparam int EDGE_W     = IDX_W + 2;
    localparam int MIN_LEN_M1 = 3;

    // Configuration word field positions
    localparam int POS_CPOL  = 31;
    localparam int POS_CPHA  = 30;
    localparam int POS_MSB   = 29;
    localparam int POS_DIV16 = 28;
    localparam int POS_PM    = 24;
    localparam int POS_LEN   = 16;

    typedef struct packed {
        logic              cpol;
        logic              cpha;
        logic              msb_first;
        logic              div16;
        logic [PM_W-1:0]   pm;
        logic [IDX_W-1:0]  len_m1;
        logic              loop;
    } char_cfg_t;

    function automatic char_cfg_t decode_cfg(input logic [CFG_W-1:0] w, input logic lp);
        char_cfg_t c;
        c.cpol      = w[POS_CPOL];
        c.cpha      = w[POS_CPHA];
        c.msb_first = w[POS_MSB];
        c.div16     = w[POS_DIV16];
        c.pm        = w[POS_PM +: PM_W];
        c.len_m1    = (w[POS_LEN +: IDX_W] < IDX_W'(MIN_LEN_M1)) ? IDX_W'(MIN_LEN_M1)
                                                                : w[POS_LEN +: IDX_W];
        c.loop      = lp;
        return c;
    endfunction

    // Edge spacing minus one, in system clock cycles
    function automatic logic [HALF_W-1:0] half_limit(input char_cfg_t c);
        logic [HALF_W-1:0] base;
        base = HALF_W'(c.pm) + HALF_W'(1);
        base = c.div16 ? (base << SLOW_SHIFT) : (base << FAST_SHIFT);
        return base - HALF_W'(1);
    endfunction

    function automatic logic [EDGE_W-1:0] edge_total(input char_cfg_t c);
        return (EDGE_W'(c.len_m1) + EDGE_W'(1)) << 1;
    endfunction

    function automatic logic [IDX_W-1:0] bit_pos(input logic [IDX_W-1:0] len_m1,
                                                  input logic msb,
                                                  input logic [IDX_W-1:0] idx);
        return msb ? (len_m1 - idx) : idx;
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int HALF_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              run,
    input  logic [HALF_W-1:0] limit,
    output logic              tick
);
    logic [HALF_W-1:0] cnt;

    assign tick = run && !clear && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == limit) ? '0 : cnt + HALF_W'(1);
        end
    end
endmodule

// File: rtl/spi_char_engine.sv
module spi_char_engine
    import spi_shift_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic               tick,
    input  char_cfg_t          cfg_in,
    input  logic [CHAR_W-1:0]  tx_char,
    input  logic               miso,
    output logic               busy,
    output logic               done,
    output logic               sck,
    output logic               mosi,
    output logic [CHAR_W-1:0]  rx_char,
    output logic [HALF_W-1:0]  half_lim
);
    char_cfg_t          cur;
    logic [CHAR_W-1:0]  txd;
    logic [CHAR_W-1:0]  rx_acc;
    logic [CHAR_W-1:0]  rx_upd;
    logic [EDGE_W-1:0]  ecnt;
    logic [EDGE_W-1:0]  enext;
    logic               leading;
    logic               last;
    logic               sample_en;
    logic               drive_en;
    logic               din;
    logic               tx_next;

    assign half_lim = half_limit(cur);

    always_comb begin
        enext     = ecnt + EDGE_W'(1);
        leading   = enext[0];
        last      = (enext == edge_total(cur));
        // phase 0 samples on leading edges, phase 1 on trailing edges
        sample_en = tick && (leading ^ cur.cpha);
        drive_en  = tick && !last && (leading == cur.cpha);
        din       = cur.loop ? mosi : miso;
        rx_upd    = rx_acc;
        if (sample_en) begin
            rx_upd[bit_pos(cur.len_m1, cur.msb_first, ecnt[IDX_W:1])] = din;
        end
        tx_next   = txd[bit_pos(cur.len_m1, cur.msb_first, enext[IDX_W:1])];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            txd     <= '0;
            rx_acc  <= '0;
            rx_char <= '0;
            ecnt    <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            sck     <= 1'b0;
            mosi    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                cur    <= cfg_in;
                txd    <= tx_char;
                rx_acc <= '0;
                ecnt   <= '0;
                busy   <= 1'b1;
                sck    <= cfg_in.cpol;
                mosi   <= tx_char[bit_pos(cfg_in.len_m1, cfg_in.msb_first, '0)];
            end else if (busy) begin
                if (tick) begin
                    sck    <= ~sck;
                    ecnt   <= enext;
                    rx_acc <= rx_upd;
                    if (drive_en) begin
                        mosi <= tx_next;
                    end
                    if (last) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        rx_char <= rx_upd;
                        mosi    <= 1'b0;
                    end
                end
            end else begin
                sck <= cfg_in.cpol;
            end
        end
    end
endmodule

// File: rtl/spi_char_shifter.sv
module spi_char_shifter
    import spi_shift_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CFG_W-1:0]   cfg_word,
    input  logic               loop_en,
    input  logic               start,
    input  logic [CHAR_W-1:0]  tx_char,
    input  logic               miso,
    output logic               busy,
    output logic               done,
    output logic               sck,
    output logic               mosi,
    output logic [CHAR_W-1:0]  rx_char
);
    char_cfg_t          cfg_dec;
    logic               go;
    logic               tick;
    logic [HALF_W-1:0]  half_lim;

    assign cfg_dec = decode_cfg(cfg_word, loop_en);
    assign go      = start && !busy;

    spi_half_timer #(.HALF_W(HALF_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (go),
        .run   (busy),
        .limit (half_lim),
        .tick  (tick)
    );

    spi_char_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .tick     (tick),
        .cfg_in   (cfg_dec),
        .tx_char  (tx_char),
        .miso     (miso),
        .busy     (busy),
        .done     (done),
        .sck      (sck),
        .mosi     (mosi),
        .rx_char  (rx_char),
        .half_lim (half_lim)
    );
endmodule

// File: rtl/spi_char_shifter_chk.sv
module spi_char_shifter_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] cfg_word,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        sck,
    input logic        mosi
);
    int   exp_gap;
    int   exp_len;
    int   gap;
    int   run_len;
    logic sck_prev;
    logic busy_prev;
    logic accept;

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_gap   <= 0;
            exp_len   <= 0;
            gap       <= 0;
            run_len   <= 0;
            sck_prev  <= 1'b0;
            busy_prev <= 1'b0;
        end else begin
            sck_prev  <= sck;
            busy_prev <= busy;
            if (accept) begin
                exp_gap <= 2 * (int'(cfg_word[27:24]) + 1) * (cfg_word[28] ? 16 : 1);
                exp_len <= 2 * ((cfg_word[19:16] < 4'd3) ? 4 : int'(cfg_word[19:16]) + 1)
                             * 2 * (int'(cfg_word[27:24]) + 1) * (cfg_word[28] ? 16 : 1);
                gap     <= 0;
                run_len <= 0;
            end else begin
                gap <= (busy_prev && sck != sck_prev) ? 1 : gap + 1;
                if (busy) run_len <= run_len + 1;
            end
        end
    end

    // R1 and R2: spacing between serial clock edges within a character
    assert_edge_gap_R1: assert property (@(posedge clk) disable iff (rst)
        (busy_prev && sck != sck_prev) |-> gap == exp_gap);

    // R3: character duration
    assert_char_len_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> run_len == exp_len);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_end_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_start_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_idle_pol_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy && !start && !rst)) |-> sck == $past(cfg_word[31]));

    assert_mosi_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mosi);
endmodule

bind spi_char_shifter spi_char_shifter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_word (cfg_word),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .sck      (sck),
    .mosi     (mosi)
);

// File: tb/spi_char_shifter_tb.sv
module spi_char_shifter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        loop_en = 1'b0;
    logic        start = 1'b0;
    logic [15:0] tx_char = '0;
    logic        miso = 1'b0;
    logic        busy, done, sck, mosi;
    logic [15:0] rx_char;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    bit          m_run = 0;
    int          e = 0;
    int          mH = 1, mN = 4;
    bit          m_cpol, m_cpha, m_msb, m_loop;
    logic [15:0] m_tx, m_sw;
    logic [15:0] slave_word = '0;
    bit          cpol_prev = 0;
    int          lc = 0, tc = 0;

    always #2.5 clk = ~clk;

    spi_char_shifter u_dut (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .loop_en(loop_en),
        .start(start), .tx_char(tx_char), .miso(miso), .busy(busy),
        .done(done), .sck(sck), .mosi(mosi), .rx_char(rx_char)
    );

    function automatic int bpos(int n, bit msb, int i);
        return msb ? (n - 1 - i) : i;
    endfunction

    function automatic logic [31:0] mk(bit cpol, bit cpha, bit msb, bit d16, int pm, int lenm1);
        return {cpol, cpha, msb, d16, 4'(pm), 4'b0, 4'(lenm1), 16'b0};
    endfunction

    function automatic logic [15:0] lenmask(int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, expv, $time);
        end
    endtask

    // model: advance on every clock edge
    always @(posedge clk) begin
        bit busy_b;
        busy_b = m_run && (e < 2 * mN * mH);
        if (rst) begin
            m_run = 0;
        end else if (start && !busy_b) begin
            m_cpol = cfg_word[31];
            m_cpha = cfg_word[30];
            m_msb  = cfg_word[29];
            mH     = 2 * (int'(cfg_word[27:24]) + 1) * (cfg_word[28] ? 16 : 1);
            mN     = (cfg_word[19:16] < 4'd3) ? 4 : int'(cfg_word[19:16]) + 1;
            m_loop = loop_en;
            m_tx   = tx_char;
            m_sw   = slave_word;
            e      = 0;
            m_run  = 1;
            lc     = 0;
            tc     = 0;
            miso   = m_sw[bpos(mN, m_msb, 0)];
        end else if (m_run) begin
            e++;
        end
        cpol_prev = cfg_word[31];
    end

    // target model driven by the serial clock
    always @(sck) begin
        if (!rst && m_run && e >= 1 && e <= 2 * mN * mH) begin
            if (sck != m_cpol) begin
                if (m_cpha && lc < mN) miso = m_sw[bpos(mN, m_msb, lc)];
                lc++;
            end else begin
                tc++;
                if (!m_cpha && tc < mN) miso = m_sw[bpos(mN, m_msb, tc)];
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit be, de, se, me;
            int k, idx;
            logic [15:0] rexp;
            if (m_run && e <= 2 * mN * mH) begin
                k  = e / mH;
                be = (e < 2 * mN * mH);
                de = (e == 2 * mN * mH);
                se = m_cpol ^ k[0];
                idx = m_cpha ? ((k == 0) ? 0 : (k - 1) / 2) : k / 2;
                me = be ? m_tx[bpos(mN, m_msb, idx)] : 1'b0;
            end else begin
                be = 0; de = 0; se = cpol_prev; me = 0;
            end
            chk(busy == be, "R3", "busy", busy, be);
            chk(done == de, "R8", "done", done, de);
            chk(sck == se, "R1/R4", "sck", sck, se);
            chk(mosi == me, "R5/R6", "mosi", mosi, me);
            if (de) begin
                rexp = (m_loop ? m_tx : m_sw) & lenmask(mN);
                chk(rx_char == rexp, "R6/R7", "rx_char", rx_char, rexp);
            end
        end
    end

    // drive a start at the current negedge, return in the done cycle
    task automatic run_char(logic [31:0] cfg, logic [15:0] tx, logic [15:0] sw, bit lp);
        cfg_word   = cfg;
        tx_char    = tx;
        slave_word = sw;
        loop_en    = lp;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(m_run && e == 2 * mN * mH)) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!busy && !done && !sck && !mosi && rx_char == 16'h0, "R11", "reset state",
            {busy, done, sck, mosi}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R6 msb first, mode 0, N=8, fastest rate
        run_char(mk(0, 0, 1, 0, 0, 7), 16'h00A5, 16'h003C, 0);
        repeat (4) @(negedge clk);
        // R4 R5 idle high, phase 1, lsb first, N=16, P=2
        run_char(mk(1, 1, 0, 0, 2, 15), 16'hC3A1, 16'h5E71, 0);
        repeat (4) @(negedge clk);
        // R5 phase 1, idle low, N=4
        run_char(mk(0, 1, 0, 0, 0, 3), 16'h000B, 16'h0006, 0);
        repeat (2) @(negedge clk);
        // R2 divide-by-16, N=5, upper tx bits must not appear
        run_char(mk(1, 0, 1, 1, 1, 4), 16'hFFF3, 16'hFFEA, 0);
        repeat (2) @(negedge clk);
        // R7 loopback: miso carries different data
        run_char(mk(0, 0, 1, 0, 3, 11), 16'h0B6D, 16'h0492, 1);
        repeat (2) @(negedge clk);
        // R3 length field below minimum treated as 4 bits
        run_char(mk(1, 0, 1, 0, 0, 0), 16'h0009, 16'h0005, 0);
        repeat (2) @(negedge clk);

        // R9 configuration changed mid character, R10 start ignored while busy
        cfg_word = mk(0, 0, 0, 0, 1, 7); tx_char = 16'h0096; slave_word = 16'h0069; loop_en = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        cfg_word = mk(1, 1, 1, 1, 9, 15); loop_en = 1; tx_char = 16'hFFFF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(m_run && e == 2 * mN * mH)) @(negedge clk);
        chk(rx_char == 16'h0069, "R9", "rx after mid-char cfg change", rx_char, 16'h0069);
        repeat (3) @(negedge clk);

        // R10 R8 back-to-back: next start in the done cycle
        run_char(mk(0, 1, 1, 0, 0, 5), 16'h002D, 16'h0033, 0);
        run_char(mk(1, 0, 0, 0, 1, 9), 16'h0271, 16'h01CE, 0);
        @(negedge clk);
        chk(rx_char == 16'h01CE, "R8", "rx held after done", rx_char, 16'h01CE);
        repeat (2) @(negedge clk);

        // R1 R2 slowest rate
        run_char(mk(0, 0, 0, 1, 15, 3), 16'h0005, 16'h000A, 0);
        repeat (4) @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule